// File: doc/BRIEF.md
# Two-Channel Interrupt Aggregator

This block collects interrupt events from two serial channels, a DMA engine and a general-purpose input port, and turns them into one active-low, level-sensitive request line to a host CPU. Each serial channel has three 8-bit event status registers. The DMA engine and the port have one status register each. Every status register has its own mask register. Event inputs are single-cycle pulses on per-bit vectors, and each pulse sets the matching status bit. The bit stays set until the host reads that status register, and the read clears the whole register.

The host first reads a read-only summary register to see which status registers hold unmasked pending events. It then reads those status registers, which clears them. A mode register holds a global block bit, which is set at reset and keeps the request line inactive until software clears it. The mode register also holds a visibility bit. When the visibility bit is set, masked channel events are still latched so that software can poll them, but they never raise the request. All registers sit on a simple 8-bit bus. Reads return data one cycle after the read strobe.

Address map with the default parameters:
- 0x00–0x02: channel A status 0–2.
- 0x03–0x05: channel B status 0–2.
- 0x06: DMA status.
- 0x07: port status.
- 0x08–0x0F: the masks, in the same order as the status registers.
- 0x10: mode register. Bit 0 is the global block bit and bit 1 is the visibility bit.
- 0x11: summary register. Bit k reports status register k.
- Any other address reads 0.

The block has no state machine. The registers are plain flops that update every cycle.

Top module: `irqagg_top`

## Requirements
- R1: After reset, irq_n is 1, every status register reads 0x00, every mask register reads 0xFF, the mode register reads 0x01 and the summary register reads 0x00.
- R2: An event pulse on a bit whose mask bit is 0 sets that status bit. Further events OR into the register, and the accumulated value is returned by a read.
- R3: A read of a status register returns its contents on bus_rdata in the next cycle and clears all its bits, so that a second read returns 0x00.
- R4: An event that arrives in the same cycle as a clearing read of its register is kept. A following read returns that event's bits.
- R5: With the visibility bit (mode bit 1) at 0, an event on a bit whose mask bit is 1 is not recorded.
- R6: With the visibility bit at 1, masked events on the six channel status registers are recorded and readable, but they do not set summary bits or assert irq_n. Masked DMA and port events are still not recorded.
- R7: irq_n is 0 exactly when the global block bit is 0 and some status bit is set with its mask bit 0. It stays 0 from the cycle after the event until the clearing read.
- R8: While the global block bit (mode bit 0) is 1, irq_n stays 1 whatever the status and mask contents.
- R9: Summary bit k (k = 0..5 for the channel A and B status registers, 6 for DMA, 7 for the port) is 1 when status register k holds an unmasked set bit. Reading the summary register clears nothing.
- R10: The map places status at 0x00–0x07, masks at 0x08–0x0F, mode at 0x10 and summary at 0x11. Writes to status or summary addresses are ignored, unmapped addresses read 0x00, and bus_rdata holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_evt | input | 48 | Channel event pulses; byte k feeds status register k (0..5) |
| dma_evt | input | 8 | DMA event pulses (status register 6) |
| port_evt | input | 8 | Port event pulses (status register 7) |
| bus_addr | input | 5 | Register byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| irq_n | output | 1 | Interrupt request, active low, level |

## Verification
An event pulse and a clearing read of the same status register can fall in the same clock cycle. The read must return the old contents, and the new event must remain set afterwards. This case is provoked once in directed form and then often in random traffic, where event pulses and reads to random addresses overlap freely. A behavioural register model in the bench predicts every read value and the level of irq_n on every cycle. Any lost or duplicated event therefore shows up as a mismatch.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    typedef enum logic [2:0] {
        RGN_STAT,
        RGN_MASK,
        RGN_MODE,
        RGN_SUMM,
        RGN_NONE
    } rgn_e;

    localparam int MODE_GIM_BIT = 0;
    localparam int MODE_VIS_BIT = 1;

endpackage

// File: rtl/irqagg_stat_reg.sv
module irqagg_stat_reg #(
    parameter int DW          = 8,
    parameter bit SHOW_MASKED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] evt,
    input  logic [DW-1:0] mask,
    input  logic          vis_en,
    input  logic          rd_clr,
    output logic [DW-1:0] stat
);

    logic [DW-1:0] rec;
    logic [DW-1:0] stat_nx;

    always_comb begin
        if (SHOW_MASKED && vis_en) rec = evt;
        else                       rec = evt & ~mask;
    end

    always_comb stat_nx = (rd_clr ? '0 : stat) | rec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_nx;
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && evt == '0) |=> (stat == '0)); // R3

    AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~mask) != '0) |=> ((stat & $past(evt & ~mask)) == $past(evt & ~mask))); // R4

    AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !(SHOW_MASKED && vis_en) |=> ((stat & ~$past(stat) & $past(mask)) == '0)); // R5

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank #(
    parameter int DW   = 8,
    parameter int NREG = 8,
    parameter int NVIS = 6,
    parameter int IW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREG*DW-1:0] evt_all,
    input  logic               vis_en,
    input  logic [NREG-1:0]    rd_clr,
    input  logic               mask_we,
    input  logic [IW-1:0]      mask_idx,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] stat_all,
    output logic [NREG*DW-1:0] mask_all,
    output logic [NREG-1:0]    pend
);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] mask_q;
        logic [DW-1:0] stat_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              mask_q <= '1;
            else if (mask_we && mask_idx == IW'(i))  mask_q <= wdata;
        end

        irqagg_stat_reg #(
            .DW          (DW),
            .SHOW_MASKED (i < NVIS)
        ) u_stat (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_all[i*DW +: DW]),
            .mask   (mask_q),
            .vis_en (vis_en),
            .rd_clr (rd_clr[i]),
            .stat   (stat_q)
        );

        assign stat_all[i*DW +: DW] = stat_q;
        assign mask_all[i*DW +: DW] = mask_q;
        assign pend[i]              = |(stat_q & ~mask_q);
    end

endmodule

// File: rtl/irqagg_bus.sv
module irqagg_bus
    import irqagg_pkg::*;
#(
    parameter int AW   = 5,
    parameter int DW   = 8,
    parameter int NREG = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic [NREG*DW-1:0] stat_all,
    input  logic [NREG*DW-1:0] mask_all,
    input  logic [NREG-1:0]    pend,
    output logic [DW-1:0]      bus_rdata,
    output logic [NREG-1:0]    rd_clr,
    output logic               mask_we,
    output logic [IW-1:0]      mask_idx,
    output logic               gim,
    output logic               vis_en
);

    localparam logic [AW-1:0] MASK_BASE = AW'(NREG);
    localparam logic [AW-1:0] MODE_ADDR = AW'(2 * NREG);
    localparam logic [AW-1:0] SUMM_ADDR = AW'(2 * NREG + 1);

    rgn_e          rgn;
    logic [IW-1:0] idx;
    logic [DW-1:0] rd_val;

    always_comb begin
        rgn = RGN_NONE;
        idx = '0;
        if (bus_addr < MASK_BASE) begin
            rgn = RGN_STAT;
            idx = IW'(bus_addr);
        end else if (bus_addr < MODE_ADDR) begin
            rgn = RGN_MASK;
            idx = IW'(bus_addr - MASK_BASE);
        end else if (bus_addr == MODE_ADDR) begin
            rgn = RGN_MODE;
        end else if (bus_addr == SUMM_ADDR) begin
            rgn = RGN_SUMM;
        end
    end

    for (genvar i = 0; i < NREG; i++) begin : g_clr
        assign rd_clr[i] = bus_rd && (rgn == RGN_STAT) && (idx == IW'(i));
    end

    assign mask_we  = bus_wr && (rgn == RGN_MASK);
    assign mask_idx = idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gim    <= 1'b1;
            vis_en <= 1'b0;
        end else if (bus_wr && rgn == RGN_MODE) begin
            gim    <= bus_wdata[MODE_GIM_BIT];
            vis_en <= bus_wdata[MODE_VIS_BIT];
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (rgn)
            RGN_STAT: rd_val = stat_all[int'(idx)*DW +: DW];
            RGN_MASK: rd_val = mask_all[int'(idx)*DW +: DW];
            RGN_MODE: begin
                rd_val[MODE_GIM_BIT] = gim;
                rd_val[MODE_VIS_BIT] = vis_en;
            end
            RGN_SUMM: rd_val = DW'(pend);
            RGN_NONE: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R10

    AST_SUMM_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == SUMM_ADDR) |-> (rd_clr == '0)); // R9

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_clr)); // R3

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top #(
    parameter int DW  = 8,
    parameter int NCH = 2,
    parameter int NSR = 3,
    parameter int AW  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH*NSR*DW-1:0] ch_evt,
    input  logic [DW-1:0]        dma_evt,
    input  logic [DW-1:0]        port_evt,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 irq_n
);

    localparam int NVIS = NCH * NSR;
    localparam int NREG = NVIS + 2;
    localparam int IW   = $clog2(NREG);

    logic [NREG*DW-1:0] evt_all;
    logic [NREG*DW-1:0] stat_all;
    logic [NREG*DW-1:0] mask_all;
    logic [NREG-1:0]    pend;
    logic [NREG-1:0]    rd_clr;
    logic               mask_we;
    logic [IW-1:0]      mask_idx;
    logic               gim;
    logic               vis_en;

    assign evt_all = {port_evt, dma_evt, ch_evt};

    irqagg_bank #(
        .DW   (DW),
        .NREG (NREG),
        .NVIS (NVIS),
        .IW   (IW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_all  (evt_all),
        .vis_en   (vis_en),
        .rd_clr   (rd_clr),
        .mask_we  (mask_we),
        .mask_idx (mask_idx),
        .wdata    (bus_wdata),
        .stat_all (stat_all),
        .mask_all (mask_all),
        .pend     (pend)
    );

    irqagg_bus #(
        .AW   (AW),
        .DW   (DW),
        .NREG (NREG),
        .IW   (IW)
    ) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .stat_all  (stat_all),
        .mask_all  (mask_all),
        .pend      (pend),
        .bus_rdata (bus_rdata),
        .rd_clr    (rd_clr),
        .mask_we   (mask_we),
        .mask_idx  (mask_idx),
        .gim       (gim),
        .vis_en    (vis_en)
    );

    assign irq_n = ~(~gim & (|pend));

    AST_GIM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        gim |-> irq_n); // R8

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((stat_all & ~mask_all) != '0)); // R7

    AST_UNMASKED_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_all & ~mask_all) != '0) |=> (pend != '0)); // R2

endmodule

// File: tb/tb_irqagg_top.sv
`timescale 1ns/1ps
module tb_irqagg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ev [8];
    logic [47:0] ch_evt;
    logic [7:0]  dma_evt, port_evt;
    logic [4:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // behavioural reference state
    logic [7:0] m_st [8];
    logic [7:0] m_mk [8];
    logic       m_gim, m_vis;
    logic [7:0] m_rdata;
    string      tag = "R1";

    always #2 clk = ~clk;

    assign ch_evt   = {ev[5], ev[4], ev[3], ev[2], ev[1], ev[0]};
    assign dma_evt  = ev[6];
    assign port_evt = ev[7];

    irqagg_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_evt    (ch_evt),
        .dma_evt   (dma_evt),
        .port_evt  (port_evt),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    function automatic logic [7:0] m_summ();
        logic [7:0] s = '0;
        for (int r = 0; r < 8; r++) s[r] = ((m_st[r] & ~m_mk[r]) != 8'h00);
        return s;
    endfunction

    function automatic logic [7:0] m_read(input int a);
        if (a < 8)   return m_st[a];
        if (a < 16)  return m_mk[a-8];
        if (a == 16) return {6'b0, m_vis, m_gim};
        if (a == 17) return m_summ();
        return 8'h00;
    endfunction

    function automatic logic m_irq();
        return !(!m_gim && m_summ() != 8'h00);
    endfunction

    task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int a = int'(bus_addr);
        if (bus_rd) m_rdata = m_read(a);
        for (int r = 0; r < 8; r++) begin
            logic [7:0] rec;
            rec = (m_vis && r < 6) ? ev[r] : (ev[r] & ~m_mk[r]);
            m_st[r] = ((bus_rd && a == r) ? 8'h00 : m_st[r]) | rec;
        end
        if (bus_wr && a >= 8 && a < 16) m_mk[a-8] = bus_wdata;
        if (bus_wr && a == 16) begin
            m_gim = bus_wdata[0];
            m_vis = bus_wdata[1];
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk({tag, " irq_n"}, {7'b0, irq_n}, {7'b0, m_irq()});   // R7
        chk({tag, " rdata"}, bus_rdata, m_rdata);
    endtask

    task automatic op(input bit rd, input bit wr, input int a, input logic [7:0] d);
        bus_rd = rd; bus_wr = wr; bus_addr = 5'(a); bus_wdata = d;
        cycle();
        bus_rd = 1'b0; bus_wr = 1'b0;
        for (int i = 0; i < 8; i++) ev[i] = 8'h00;
    endtask

    task automatic idle();
        op(1'b0, 1'b0, 0, 8'h00);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        op(1'b0, 1'b1, a, d);
    endtask

    task automatic rd_exp(input int a, input logic [7:0] e, input string t);
        op(1'b1, 1'b0, a, 8'h00);
        chk(t, bus_rdata, e);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            ev[i] = 8'h00; m_st[i] = 8'h00; m_mk[i] = 8'hFF;
        end
        m_gim = 1'b1; m_vis = 1'b0; m_rdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        tag = "R1";
        chk("R1 irq_n idle", {7'b0, irq_n}, 8'h01);
        rd_exp(16, 8'h01, "R1 mode");
        rd_exp(8,  8'hFF, "R1 mask");
        rd_exp(15, 8'hFF, "R1 mask");
        rd_exp(0,  8'h00, "R1 status");
        rd_exp(17, 8'h00, "R1 summary");

        // R8 global block holds the line
        tag = "R8";
        wr(8, 8'h00);
        ev[0] = 8'h05; idle();
        idle();
        chk("R8 blocked", {7'b0, irq_n}, 8'h01);
        tag = "R7";
        wr(16, 8'h00);
        chk("R7 asserted", {7'b0, irq_n}, 8'h00);

        // R9 summary read twice, no clear
        tag = "R9";
        rd_exp(17, 8'h01, "R9 summary");
        rd_exp(17, 8'h01, "R9 summary again");

        // R2 accumulation
        tag = "R2";
        ev[0] = 8'h30; idle();
        rd_exp(0, 8'h35, "R2 accumulate");

        // R3 clear on read
        tag = "R3";
        rd_exp(0, 8'h00, "R3 cleared");
        chk("R3 irq released", {7'b0, irq_n}, 8'h01);

        // R4 event with clearing read
        tag = "R4";
        ev[0] = 8'h80; op(1'b1, 1'b0, 0, 8'h00);
        chk("R4 old value", bus_rdata, 8'h00);
        chk("R4 irq", {7'b0, irq_n}, 8'h00);
        rd_exp(0, 8'h80, "R4 survived");

        // R5 masked not recorded
        tag = "R5";
        ev[1] = 8'hFF; idle();
        chk("R5 irq", {7'b0, irq_n}, 8'h01);
        rd_exp(1, 8'h00, "R5 dropped");

        // R6 visibility
        tag = "R6";
        wr(16, 8'h02);
        ev[1] = 8'h0F; ev[6] = 8'h01; idle();
        chk("R6 irq", {7'b0, irq_n}, 8'h01);
        rd_exp(17, 8'h00, "R6 summary");
        rd_exp(1, 8'h0F, "R6 channel visible");
        rd_exp(6, 8'h00, "R6 dma hidden");

        // R7 level behaviour
        tag = "R7";
        wr(15, 8'hFE);
        ev[7] = 8'h01; idle();
        for (int k = 0; k < 5; k++) begin
            idle();
            chk("R7 level", {7'b0, irq_n}, 8'h00);
        end
        rd_exp(17, 8'h80, "R9 port bit");
        rd_exp(7, 8'h01, "R3 port read");
        chk("R7 released", {7'b0, irq_n}, 8'h01);

        // R10 map, ignored writes, unmapped, hold
        tag = "R10";
        wr(0, 8'hAA);
        rd_exp(0, 8'h00, "R10 status write ignored");
        wr(17, 8'hFF);
        rd_exp(17, 8'h00, "R10 summary write ignored");
        rd_exp(20, 8'h00, "R10 unmapped");
        rd_exp(15, 8'hFE, "R10 mask map");
        idle(); idle();
        chk("R10 rdata hold", bus_rdata, 8'hFE);

        // mixed traffic: events overlapping reads (R4), masks, mode
        tag = "R4 mixed";
        for (int n = 0; n < 3000; n++) begin
            int a;
            for (int i = 0; i < 8; i++)
                if (($urandom % 8) == 0) ev[i] = 8'($urandom);
            a = int'($urandom % 20);
            case ($urandom % 8)
                0, 1, 2: op(1'b1, 1'b0, a, 8'h00);
                3:       op(1'b0, 1'b1, 8 + int'($urandom % 8), 8'($urandom));
                4:       op(1'b0, 1'b1, 16, {6'b0, 1'($urandom), (($urandom % 4) == 0)});
                default: idle();
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule